// File: doc/BRIEF.md
# Three-Wire Control Register Interface

This block is the write-only serial control port of an audio DAC. A host lowers chip select, clocks in a 16-bit frame on the data line, and raises chip select again. The block checks the frame and, if it is valid, loads one of three small control registers. The registers hold the DAC mode settings: a timing reset bit, master clock select, serial audio format, sampling speed, de-emphasis, soft mute, slow roll-off, zero-detect controls and output gain.

The serial lines are not used as clocks. They pass through two-flop synchronizers into the system clock domain, and their edges are detected there. For this to work, each serial clock phase and the chip select high time must last at least three system clock periods. Some fields are shared with board-level strap pins, and for those the effective value is the register bit ORed with the pin. The active-low power-down input is the block's only reset.

Top module: `dac_ctl_serial_if`

## Requirements
- R1: A frame is sent MSB first: frame bit 15 first, bit 0 last. Bits 15:14 are the chip address and must be 01. Bit 13 is the direction bit and must be 1. Bits 12:8 are the register address and bits 7:0 are the data. Each bit is taken on a rising edge of the serial clock.
- R2: Registers change only when chip select rises. After all 16 bits have been clocked in but before chip select rises, every output still shows the old settings.
- R3: Address 00h maps data bit 0 to timing_rst_n, bits 3:1 to fmt and bits 6:4 to clk_sel. Data bit 7 is discarded. The defaults are timing_rst_n = 1 and all other fields 0.
- R4: Address 01h maps data bit 0 to mute, bits 2:1 to deemph, bits 4:3 to speed, bit 5 to slow_rolloff, bit 6 to zd_and and bit 7 to zd_en. The default is all zero.
- R5: Address 02h maps data bits 7:6 to gain. Data bits 5:0 are discarded. The default is 00.
- R6: A valid frame addressed to 03h through 1Fh changes no output.
- R7: While pdn_n is low, every field sits at its default and serial traffic is ignored. After pdn_n rises, the defaults remain until a new valid write.
- R8: Writing timing_rst_n to 0 or to 1 through address 00h leaves the fields of 01h and 02h unchanged.
- R9: fmt is the register field ORed with pin_fmt, clk_sel[1] is ORed with pin_clksel1, and speed[0] is ORed with pin_speed0.
- R10: A frame is discarded if its chip address is not 01, if its direction bit is 0, or if other than exactly 16 serial clock rises occur before chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pdn_n | input | 1 | Active-low power-down; resets all registers |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock; idles high |
| sdin | input | 1 | Serial data |
| pin_fmt | input | 3 | Strap pins ORed into the audio format |
| pin_clksel1 | input | 1 | Strap pin ORed into clock select bit 1 |
| pin_speed0 | input | 1 | Strap pin ORed into speed bit 0 |
| timing_rst_n | output | 1 | Internal timing reset, active low |
| clk_sel | output | 3 | Master clock ratio select |
| fmt | output | 3 | Serial audio format select |
| speed | output | 2 | Sampling speed select |
| deemph | output | 2 | De-emphasis select |
| mute | output | 1 | Soft mute request |
| slow_rolloff | output | 1 | Slow roll-off filter select |
| zd_and | output | 1 | Zero-detect channels-combined mode |
| zd_en | output | 1 | Zero-detect enable |
| gain | output | 2 | Output gain select |

## Verification
The main write path is driven by a table of frames. The table uses all-ones data, all-zero data and alternating bit patterns on each of the three registers, so that a swapped, shifted or dropped field shows up as a wrong bit in the 17-bit output word. Other frames in the table carry a bad chip address, a cleared direction bit, or an address above 02h; if any of them is accepted, an output changes that should have held. Directed tests add frames of 15 and 17 clocks, and a check taken after the sixteenth bit but before chip select rises, which separates a commit on the last bit from a commit on chip select. Further tests set each strap pin with its register bit clear, and send serial traffic during power-down.

// File: rtl/dac_ctl_serial_if.sv
module dac_ctl_serial_if #(
  parameter int          FRAME_BITS = 16,
  parameter logic [1:0]  CHIP_ID    = 2'b01
) (
  input  logic       clk,
  input  logic       pdn_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdin,
  input  logic [2:0] pin_fmt,
  input  logic       pin_clksel1,
  input  logic       pin_speed0,
  output logic       timing_rst_n,
  output logic [2:0] clk_sel,
  output logic [2:0] fmt,
  output logic [1:0] speed,
  output logic [1:0] deemph,
  output logic       mute,
  output logic       slow_rolloff,
  output logic       zd_and,
  output logic       zd_en,
  output logic [1:0] gain
);
  localparam int CW = $clog2(FRAME_BITS + 2);

  logic [2:0] cs_s, ck_s;
  logic [1:0] di_s;
  logic [CW-1:0] cnt;
  logic [FRAME_BITS-1:0] sh;
  logic [6:0] r0;
  logic [7:0] r1;
  logic [1:0] ga;

  wire bit_rise = ck_s[1] & ~ck_s[2];
  wire cs_rise  = cs_s[1] & ~cs_s[2];
  wire cs_idle  = cs_s[2];
  wire [4:0] addr = sh[12:8];
  wire commit = cs_rise && (cnt == CW'(FRAME_BITS)) && (sh[15:14] == CHIP_ID) && sh[13];

  always_ff @(posedge clk or negedge pdn_n)
    if (!pdn_n) begin
      cs_s <= '1;
      ck_s <= '1;
      di_s <= '0;
    end else begin
      cs_s <= {cs_s[1:0], cs_n};
      ck_s <= {ck_s[1:0], sclk};
      di_s <= {di_s[0], sdin};
    end

  always_ff @(posedge clk or negedge pdn_n)
    if (!pdn_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (cs_idle) begin
      cnt <= '0;
    end else if (bit_rise) begin
      sh <= {sh[FRAME_BITS-2:0], di_s[1]};
      if (cnt <= CW'(FRAME_BITS)) cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge pdn_n)
    if (!pdn_n) begin
      r0 <= 7'h01;
      r1 <= '0;
      ga <= '0;
    end else if (commit) begin
      case (addr)
        5'd0:    r0 <= sh[6:0];
        5'd1:    r1 <= sh[7:0];
        5'd2:    ga <= sh[7:6];
        default: ;
      endcase
    end

  assign timing_rst_n = r0[0];
  assign fmt          = r0[3:1] | pin_fmt;
  assign clk_sel      = {r0[6], r0[5] | pin_clksel1, r0[4]};
  assign mute         = r1[0];
  assign deemph       = r1[2:1];
  assign speed        = {r1[4], r1[3] | pin_speed0};
  assign slow_rolloff = r1[5];
  assign zd_and       = r1[6];
  assign zd_en        = r1[7];
  assign gain         = ga;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!pdn_n)
    !cs_rise |=> $stable({r0, r1, ga}));
  assert_hi_addr_R6: assert property (@(posedge clk) disable iff (!pdn_n)
    (cs_rise && addr > 5'd2) |=> $stable({r0, r1, ga}));
  assert_bad_len_R10: assert property (@(posedge clk) disable iff (!pdn_n)
    (cs_rise && cnt != CW'(FRAME_BITS)) |=> $stable({r0, r1, ga}));
  assert_bad_hdr_R1: assert property (@(posedge clk) disable iff (!pdn_n)
    (cs_rise && (sh[15:14] != CHIP_ID || !sh[13])) |=> $stable({r0, r1, ga}));
  assert_rst_keep_R8: assert property (@(posedge clk) disable iff (!pdn_n)
    (cs_rise && addr == 5'd0) |=> $stable({r1, ga}));
endmodule

// File: tb/dac_ctl_serial_if_tb.sv
module dac_ctl_serial_if_tb;
  logic clk = 0, pdn_n = 0, cs_n = 1, sclk = 1, sdin = 0;
  logic [2:0] pin_fmt = 0;
  logic pin_clksel1 = 0, pin_speed0 = 0;
  logic timing_rst_n, mute, slow_rolloff, zd_and, zd_en;
  logic [2:0] clk_sel, fmt;
  logic [1:0] speed, deemph, gain;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dac_ctl_serial_if u_dut (.clk, .pdn_n, .cs_n, .sclk, .sdin, .pin_fmt, .pin_clksel1,
    .pin_speed0, .timing_rst_n, .clk_sel, .fmt, .speed, .deemph, .mute, .slow_rolloff,
    .zd_and, .zd_en, .gain);

  // {rst_n, clk_sel[3], fmt[3], speed[2], deemph[2], mute, slow, zd_and, zd_en, gain[2]}
  localparam logic [16:0] DEF = 17'b1_000_000_00_00_0_0_0_0_00;
  localparam logic [32:0] VEC [15] = '{
    {16'h6000, 17'b0_000_000_00_00_0_0_0_0_00},  // R3 clear
    {16'h60FF, 17'b1_111_111_00_00_0_0_0_0_00},  // R3 bit7 dropped
    {16'h6054, 17'b0_101_010_00_00_0_0_0_0_00},  // R1 R3 pattern
    {16'h61A5, 17'b0_101_010_00_10_1_1_0_1_00},  // R4
    {16'h625F, 17'b0_101_010_00_10_1_1_0_1_01},  // R5 test bits dropped
    {16'h63FF, 17'b0_101_010_00_10_1_1_0_1_01},  // R6
    {16'h7F00, 17'b0_101_010_00_10_1_1_0_1_01},  // R6
    {16'h615A, 17'b0_101_010_11_01_0_0_1_0_01},  // R4
    {16'h62C0, 17'b0_101_010_11_01_0_0_1_0_11},  // R5
    {16'h2001, 17'b0_101_010_11_01_0_0_1_0_11},  // R10 chip addr 00
    {16'h4001, 17'b0_101_010_11_01_0_0_1_0_11},  // R10 direction 0
    {16'hE001, 17'b0_101_010_11_01_0_0_1_0_11},  // R10 chip addr 11
    {16'h6001, 17'b1_000_000_11_01_0_0_1_0_11},  // R8 set
    {16'h6000, 17'b0_000_000_11_01_0_0_1_0_11},  // R8 clear
    {16'h6100, 17'b0_000_000_00_00_0_0_0_0_11}   // R4 clear
  };

  function automatic logic [16:0] outs();
    return {timing_rst_n, clk_sel, fmt, speed, deemph, mute, slow_rolloff, zd_and, zd_en, gain};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %b exp %b", tag, got, exp);
    end
  endtask

  task automatic shift_bits(input logic [16:0] v, input int n);
    cs_n = 0;
    wait_clk(3);
    for (int i = n - 1; i >= 0; i--) begin
      sdin = v[i]; sclk = 0; wait_clk(4);
      sclk = 1; wait_clk(4);
    end
  endtask

  task automatic end_frame();
    cs_n = 1;
    wait_clk(8);
  endtask

  task automatic send(input logic [15:0] f);
    shift_bits({1'b0, f}, 16);
    end_frame();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    wait_clk(3);
    check("R7 reset defaults", outs(), DEF);
    pdn_n = 1;
    wait_clk(4);
    check("R7 defaults after release", outs(), DEF);

    for (int k = 0; k < 15; k++) begin
      send(VEC[k][32:17]);
      check($sformatf("R1 R3 R4 R5 R6 R8 R10 vector %0d", k), outs(), VEC[k][16:0]);
    end

    shift_bits({1'b0, 16'h6001}, 17);
    end_frame();
    check("R10 17-clock frame", outs(), VEC[14][16:0]);
    shift_bits(17'h03001, 15);
    end_frame();
    check("R10 15-clock frame", outs(), VEC[14][16:0]);

    shift_bits({1'b0, 16'h60FF}, 16);
    wait_clk(6);
    check("R2 no commit before cs rise", outs(), VEC[14][16:0]);
    end_frame();
    check("R2 commit on cs rise", outs(), 17'b1_111_111_00_00_0_0_0_0_11);

    send(16'h6000);
    pin_fmt = 3'b101; wait_clk(1);
    check("R9 fmt pins", {14'd0, fmt}, {14'd0, 3'b101});
    pin_fmt = 0; pin_clksel1 = 1; wait_clk(1);
    check("R9 clk_sel pin", {14'd0, clk_sel}, {14'd0, 3'b010});
    pin_clksel1 = 0; pin_speed0 = 1; wait_clk(1);
    check("R9 speed pin", {15'd0, speed}, {15'd0, 2'b01});
    pin_speed0 = 0;

    send(16'h61FF);
    send(16'h62C0);
    pdn_n = 0; wait_clk(2);
    check("R7 power-down restores defaults", outs(), DEF);
    send(16'h6000);
    pdn_n = 1; wait_clk(6);
    check("R7 write during power-down ignored", outs(), DEF);

    finished = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog got hang exp completion");
      finish_run();
    end
  end
endmodule